// File: doc/BRIEF.md
# UART Receive FIFO with Trigger Level and Character Timeout

This block is the receive-side character queue of a 16550-style serial port. The receive shift register pushes each assembled character into it, and the bus side pulls characters out by pulsing a read strobe. The oldest character is always visible on the read data output. The queue reports its fill count and whether it is empty. A write that arrives while the queue is full is discarded and raises a sticky overrun flag.

Two conditions are flagged for the interrupt logic. The first is a level flag, which is high while the fill count is at or above a threshold. Software picks that threshold with a two-bit code. The second is a character-timeout flag, which rises when characters have sat in the queue with no read or write for four character times. One character time is the frame length in bit-time ticks. The surrounding receiver supplies the frame length and a one-cycle tick per bit time.

Top module: `uart_rx_queue`

## Requirements
- R1: Characters leave in the order they were written. `rd_data` shows the oldest stored character, and a `pop` while non-empty removes it on the next clock edge. The storage holds 16 characters.
- R2: `count` equals the number of stored characters (0 to 16), and `empty` is high exactly when `count` is 0. A `pop` while empty has no effect.
- R3: A `push` while `count` is 16 with no `pop` in the same cycle is dropped. It sets `overrun`, which stays high until `fifo_clr` or reset. A `push` and a `pop` in the same cycle while full are both accepted.
- R4: `trig_we` loads `trig_code` into the trigger setting. Codes 2'b00, 2'b01, 2'b10 and 2'b11 select thresholds of 1, 4, 8 and 14 characters. After reset the setting is 2'b11 (14).
- R5: `level_hit` is high exactly while `count` is at or above the selected threshold.
- R6: While the queue is non-empty, `char_timeout` rises on the clock edge that takes in the 4*`frame_len`-th `bit_tick` counted with no access. It is still low after 4*`frame_len`-1 such ticks.
- R7: Any accepted `push` or `pop` restarts the idle tick count from zero.
- R8: A `pop` of a stored character clears `char_timeout` on the next edge.
- R9: While the queue is empty, the idle count is held at zero and `char_timeout` stays low, whatever ticks arrive.
- R10: `fifo_clr` empties the queue. It clears `count`, `char_timeout` and `overrun` and leaves the trigger setting unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push | input | 1 | Write strobe from the receive shift register |
| push_data | input | 8 | Character to store |
| pop | input | 1 | Read strobe from the bus side |
| trig_we | input | 1 | Load strobe for the trigger code |
| trig_code | input | 2 | Trigger level code |
| fifo_clr | input | 1 | Synchronous queue clear |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| frame_len | input | 4 | Ticks per character frame (start, data, parity, stop) |
| rd_data | output | 8 | Oldest stored character |
| count | output | 5 | Number of stored characters |
| empty | output | 1 | Queue holds no character |
| overrun | output | 1 | Sticky flag for a dropped write |
| level_hit | output | 1 | Fill count at or above the trigger threshold |
| char_timeout | output | 1 | Character-timeout flag |

## Verification
Assertions check on every cycle that the count never exceeds the depth, that an accepted lone write raises the count by one, that a write into a full queue raises the overrun flag, and that the timeout flag never stands high over an empty queue. They also check that a read and a queue clear drop the timeout flag. The bench scenarios cover the rest. They show the exact tick at which the timeout rises for a given frame length, the restart of the idle count when a write lands mid-wait, and the ordering of the characters read back. They also check the threshold for each trigger code and that the trigger setting survives a queue clear.

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int FLEN_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  input  logic                       trig_we,
  input  logic [1:0]                 trig_code,
  input  logic                       fifo_clr,
  input  logic                       bit_tick,
  input  logic [FLEN_W-1:0]          frame_len,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       overrun,
  output logic                       level_hit,
  output logic                       char_timeout
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int IW = FLEN_W + 2;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [1:0]    trig_q;
  logic [IW-1:0] idle, limit;
  logic [CW-1:0] thresh;
  logic          full, take, give, access;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign give   = pop && !empty;
  assign take   = push && (!full || give);
  assign access = take || give;
  assign rd_data = mem[rp];
  assign limit  = {frame_len, 2'b00};

  always_comb begin
    case (trig_q)
      2'b00:   thresh = CW'(1);
      2'b01:   thresh = CW'(4);
      2'b10:   thresh = CW'(8);
      default: thresh = CW'(14);
    endcase
  end
  assign level_hit = (count >= thresh);

  always_ff @(posedge clk) begin
    if (take) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; overrun <= 1'b0;
    end else if (fifo_clr) begin
      wp <= '0; rp <= '0; count <= '0; overrun <= 1'b0;
    end else begin
      if (take) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (give) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (take && !give)      count <= count + 1'b1;
      else if (give && !take) count <= count - 1'b1;
      if (push && !take) overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trig_q <= 2'b11;
    else if (trig_we) trig_q <= trig_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle <= '0; char_timeout <= 1'b0;
    end else if (fifo_clr) begin
      idle <= '0; char_timeout <= 1'b0;
    end else begin
      if (give) char_timeout <= 1'b0;
      if (access || empty) begin
        idle <= '0;
      end else if (bit_tick && idle < limit) begin
        idle <= idle + 1'b1;
        if (idle + 1'b1 >= limit) char_timeout <= 1'b1;
      end
    end
  end

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R2
  push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop && !fifo_clr) |=> count == $past(count) + 1'b1);
  // R3
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !fifo_clr) |=> overrun && count == CW'(DEPTH));
  // R9
  empty_no_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !char_timeout);
  // R8
  pop_clears_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty) |=> !char_timeout);
  // R10
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (count == '0 && !char_timeout && !overrun));
endmodule

// File: tb/test_uart_rx_queue.sv
module test_uart_rx_queue;
  logic clk = 0, rst_n = 0;
  logic push = 0, pop = 0, trig_we = 0, fifo_clr = 0, bit_tick = 0;
  logic [7:0] push_data = 0;
  logic [1:0] trig_code = 0;
  logic [3:0] frame_len = 4'd10;
  logic [7:0] rd_data;
  logic [4:0] count;
  logic empty, overrun, level_hit, char_timeout;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_queue i_uart_rx_queue (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); push = 1; push_data = d;
    @(negedge clk); push = 0;
  endtask
  task automatic rd();
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
  endtask
  task automatic clr();
    @(negedge clk); fifo_clr = 1;
    @(negedge clk); fifo_clr = 0;
  endtask
  task automatic set_trig(input logic [1:0] c);
    @(negedge clk); trig_we = 1; trig_code = c;
    @(negedge clk); trig_we = 0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
    end
  endtask

  task automatic t_reset();
    check(count == 0, "R2 reset count", count, 0);
    check(empty == 1, "R2 reset empty", empty, 1);
    check(overrun == 0 && char_timeout == 0, "R10 reset flags", overrun, 0);
  endtask

  task automatic t_default_trigger();
    for (int i = 0; i < 13; i++) wr(8'(i));
    check(level_hit == 0, "R4 default 14 at 13", level_hit, 0);
    wr(8'd13);
    check(level_hit == 1, "R4 default 14 at 14", level_hit, 1);
    clr();
  endtask

  task automatic t_order_overrun();
    for (int i = 0; i < 16; i++) wr(8'(8'h40 + i));
    check(count == 16, "R1 full count", count, 16);
    check(overrun == 0, "R3 no overrun yet", overrun, 0);
    wr(8'hEE);
    check(overrun == 1, "R3 overrun set", overrun, 1);
    check(count == 16, "R3 count held", count, 16);
    @(negedge clk); push = 1; push_data = 8'h77; pop = 1;
    @(negedge clk); push = 0; pop = 0;
    check(count == 16, "R3 push+pop when full", count, 16);
    for (int i = 1; i < 16; i++) begin
      check(rd_data == 8'(8'h40 + i), "R1 order", rd_data, 8'h40 + i);
      rd();
    end
    check(rd_data == 8'h77, "R1 last accepted", rd_data, 8'h77);
    rd();
    check(empty == 1, "R2 drained", empty, 1);
    rd();
    check(count == 0, "R2 pop empty ignored", count, 0);
    check(overrun == 1, "R3 overrun sticky", overrun, 1);
    clr();
    check(overrun == 0, "R10 clear overrun", overrun, 0);
  endtask

  task automatic t_levels();
    set_trig(2'b01);
    for (int i = 0; i < 3; i++) wr(8'h11);
    check(level_hit == 0, "R5 code01 at 3", level_hit, 0);
    wr(8'h11);
    check(level_hit == 1, "R5 code01 at 4", level_hit, 1);
    rd();
    check(level_hit == 0, "R5 drop below 4", level_hit, 0);
    clr();
    set_trig(2'b00);
    check(level_hit == 0, "R4 code00 empty", level_hit, 0);
    wr(8'h22);
    check(level_hit == 1, "R4 code00 at 1", level_hit, 1);
    clr();
    set_trig(2'b10);
    for (int i = 0; i < 7; i++) wr(8'h33);
    check(level_hit == 0, "R4 code10 at 7", level_hit, 0);
    wr(8'h33);
    check(level_hit == 1, "R4 code10 at 8", level_hit, 1);
    clr();
    check(count == 0 && level_hit == 0, "R10 clear empties", count, 0);
    for (int i = 0; i < 8; i++) wr(8'h44);
    check(level_hit == 1, "R10 trigger kept", level_hit, 1);
    clr();
  endtask

  task automatic t_timeout();
    frame_len = 4'd10;
    ticks(50);
    check(char_timeout == 0, "R9 empty no timeout", char_timeout, 0);
    wr(8'hA1); wr(8'hA2);
    ticks(39);
    check(char_timeout == 0, "R6 39 ticks low", char_timeout, 0);
    ticks(1);
    check(char_timeout == 1, "R6 40 ticks high", char_timeout, 1);
    rd();
    check(char_timeout == 0, "R8 read clears", char_timeout, 0);
    ticks(30);
    wr(8'hA3);
    ticks(30);
    check(char_timeout == 0, "R7 write restarts", char_timeout, 0);
    ticks(10);
    check(char_timeout == 1, "R7 full wait after write", char_timeout, 1);
    clr();
    check(char_timeout == 0, "R10 clear timeout", char_timeout, 0);
    frame_len = 4'd7;
    wr(8'hB0);
    ticks(27);
    check(char_timeout == 0, "R6 frame7 27 low", char_timeout, 0);
    ticks(1);
    check(char_timeout == 1, "R6 frame7 28 high", char_timeout, 1);
    rd();
    ticks(60);
    check(char_timeout == 0, "R9 empty after drain", char_timeout, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_default_trigger();
    t_order_overrun();
    t_levels();
    t_timeout();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule